// File: doc/BRIEF.md
# Periodic Event Count Logger

This block watches one hardware activity line, such as a pipeline stall or a cache miss, and turns it into a time series. In counting mode a counter adds one for every clock cycle in which the activity line is high, the global enable is set and the block's own mask bit is set. A periodic log strobe arrives from an outside control unit. On each strobe the count for the interval that just ended is written into a local sample store at the next free index. The counter restarts in that same cycle, so every record holds one interval's count.

In value mode the block does no counting. On each strobe it records a sampled word taken from a data input, such as a processor's program counter, and uses the same store and the same index sequence as counting mode. A start pulse from the control unit empties the log. After a profiling run the host reads any record by its index through a synchronous read port. The block also reports how many records are held and whether the store is full.

Top module: `evlog_monitor`

## Requirements
- R1: In counting mode (mode_i = 0) the internal count grows by exactly one in each cycle where event_i, enable_i and mask_i are all 1. It holds in any other cycle that has no strobe or start.
- R2: On a cycle with strobe_i = 1 and start_i = 0, the count collected before that cycle is written to record index rec_count_o. The counter then restarts for the new interval.
- R3: Records are stored at consecutive indices 0, 1, 2, ... in strobe order, and rec_count_o equals the number of records stored.
- R4: An event that is active in the same cycle as a strobe belongs to the new interval. The next record starts from 1 instead of 0.
- R5: Once DEPTH records (256 by default) are stored, full_o is 1 and rec_count_o stays at DEPTH. Further strobes change no record and leave full_o at 1 until a start.
- R6: In value mode (mode_i = 1) a strobe stores value_i as the record, and activity on event_i is not counted.
- R7: start_i = 1 clears the record count, full_o and the counter. A strobe in the same cycle as a start writes nothing.
- R8: The counter saturates at all ones of the record width (0xFFFFFFFF by default) instead of wrapping.
- R9: rd_data_o shows the record at rd_addr_i one clock cycle after the address is presented.
- R10: After reset, rec_count_o is 0 and full_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears the log and the counter |
| enable_i | input | 1 | Global profiling enable |
| mask_i | input | 1 | Per-monitor enable |
| mode_i | input | 1 | 0 = count events, 1 = capture value_i |
| event_i | input | 1 | Activity line being counted |
| value_i | input | DATA_W | Word captured in value mode |
| strobe_i | input | 1 | Periodic log strobe |
| rd_addr_i | input | log2(DEPTH) | Record index to read |
| rd_data_o | output | DATA_W | Record data, one cycle after the address |
| rec_count_o | output | log2(DEPTH+1) | Number of records stored |
| full_o | output | 1 | All DEPTH records are in use |

## Verification
The count path is driven with solid runs of activity, with an alternating pattern and with activity hidden by a low enable or a low mask. A record that matches only the qualified cycles shows that the gating works. A strobe is placed in the same cycle as an event and then again right after it, which separates the new-interval rule from an off-by-one in clearing. Value mode is mixed with live activity, so stray counts would appear in the next count record. A full fill followed by extra strobes, a start pulse colliding with a strobe, and a long run into a narrow-width instance cover the stop-at-full, start priority and saturation behaviour.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_VALUE = 1'b1
    } log_mode_e;

    // Qualified control for one cycle
    typedef struct packed {
        logic start;   // clear the log
        logic strobe;  // close the current interval
        logic active;  // a countable event this cycle
    } ctl_t;

    function automatic logic qualify_event(input log_mode_e mode,
                                           input logic ev,
                                           input logic en,
                                           input logic msk);
        return (mode == MODE_COUNT) && ev && en && msk;
    endfunction

endpackage

// File: rtl/evlog_counter.sv
module evlog_counter
    import evlog_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.start) begin
            cnt_q <= '0;
        end else if (ctl.strobe) begin
            // an event in the strobe cycle opens the new interval
            cnt_q <= ctl.active ? CNT_ONE : '0;
        end else if (ctl.active && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt_o = cnt_q;

    // R8: saturated count never wraps
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !ctl.strobe && !ctl.start) |=> (cnt_q == CNT_MAX));

    // R1: one step per qualified cycle
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (ctl.active && !ctl.strobe && !ctl.start && cnt_q != CNT_MAX)
            |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R1: idle cycles hold the count
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.active && !ctl.strobe && !ctl.start) |=> $stable(cnt_q));

    // R4: event on strobe restarts at one
    a_r4_restart_one: assert property (@(posedge clk) disable iff (rst)
        (ctl.strobe && ctl.active && !ctl.start) |=> (cnt_q == CNT_ONE));

endmodule

// File: rtl/evlog_wrptr.sv
module evlog_wrptr #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          strobe,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [PW-1:0] count_o,
    output logic          full_o
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH);

    logic [PW-1:0] ptr_q;
    logic          full;

    assign full = (ptr_q == LAST);
    assign we_o = strobe && !start && !full;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            ptr_q <= '0;
        end else if (we_o) begin
            ptr_q <= ptr_q + PW'(1);
        end
    end

    assign addr_o  = ptr_q[AW-1:0];
    assign count_o = ptr_q;
    assign full_o  = full;

    // R3: one step per accepted strobe
    a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (strobe && !start && !full) |=> (ptr_q == $past(ptr_q) + PW'(1)));

    // R5: full holds until start
    a_r5_full_sticky: assert property (@(posedge clk) disable iff (rst)
        (full && !start) |=> full);

    // R7: start empties the log
    a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (ptr_q == '0));

endmodule

// File: rtl/evlog_store.sv
module evlog_store #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // registered read: old contents on a same-address collision
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/evlog_monitor.sv
module evlog_monitor
    import evlog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              enable_i,
    input  logic              mask_i,
    input  logic              mode_i,
    input  logic              event_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic              strobe_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [PW-1:0]     rec_count_o,
    output logic              full_o
);
    log_mode_e         mode;
    ctl_t              ctl;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] wr_data;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;

    assign mode       = log_mode_e'(mode_i);
    assign ctl.start  = start_i;
    assign ctl.strobe = strobe_i;
    assign ctl.active = qualify_event(mode, event_i, enable_i, mask_i);

    evlog_counter #(.W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .cnt_o (cnt)
    );

    evlog_wrptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .strobe  (strobe_i),
        .we_o    (wr_en),
        .addr_o  (wr_addr),
        .count_o (rec_count_o),
        .full_o  (full_o)
    );

    always_comb begin
        unique case (mode)
            MODE_VALUE: wr_data = value_i;
            default:    wr_data = cnt;
        endcase
    end

    evlog_store #(.W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr_i),
        .rdata (rd_data_o)
    );

    // R5: nothing written once full
    a_r5_no_write_full: assert property (@(posedge clk) disable iff (rst)
        full_o |-> !wr_en);

    // R7: start blocks a colliding strobe
    a_r7_start_wins: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !wr_en);

    // R6: value mode leaves counter idle between strobes
    a_r6_value_no_count: assert property (@(posedge clk) disable iff (rst)
        (mode_i && !strobe_i && !start_i) |=> $stable(cnt));

endmodule

// File: tb/evlog_monitor_tb.sv
module evlog_monitor_tb;
    localparam int DW = 32;
    localparam int DP = 256;
    localparam int SDW = 8;
    localparam int SDP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, enable_i = 0, mask_i = 0, mode_i = 0, event_i = 0, strobe_i = 0;
    logic [DW-1:0] value_i = '0;
    logic [7:0]    rd_addr_i = '0;
    logic [DW-1:0] rd_data_o;
    logic [8:0]    rec_count_o;
    logic          full_o;

    logic s_event = 0, s_strobe = 0;
    logic [1:0]     s_rd_addr = '0;
    logic [SDW-1:0] s_rd_data;
    logic [2:0]     s_count;
    logic           s_full;

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_mem [DP];

    logic rd_vld = 0;
    logic [DW-1:0] exp_q [$];
    string tag_q [$];

    always #10 clk = ~clk;

    evlog_monitor #(.DATA_W(DW), .DEPTH(DP)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .enable_i(enable_i),
        .mask_i(mask_i), .mode_i(mode_i), .event_i(event_i), .value_i(value_i),
        .strobe_i(strobe_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .rec_count_o(rec_count_o), .full_o(full_o)
    );

    evlog_monitor #(.DATA_W(SDW), .DEPTH(SDP)) u_sat (
        .clk(clk), .rst(rst), .start_i(1'b0), .enable_i(1'b1),
        .mask_i(1'b1), .mode_i(1'b0), .event_i(s_event), .value_i(8'h00),
        .strobe_i(s_strobe), .rd_addr_i(s_rd_addr), .rd_data_o(s_rd_data),
        .rec_count_o(s_count), .full_o(s_full)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compare one cycle after the address was driven (R9)
    always @(posedge clk) begin
        #5;
        if (rd_vld && exp_q.size() > 0) begin
            check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
        end
    end

    task automatic rd(input int a, input logic [DW-1:0] e, input string tag);
        rd_addr_i = 8'(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_vld = 1'b1;
        @(negedge clk);
        rd_vld = 1'b0;
    endtask

    task automatic tick(input logic ev);
        event_i = ev; strobe_i = 0;
        @(negedge clk);
    endtask

    task automatic strobe(input logic ev);
        event_i = ev; strobe_i = 1;
        @(negedge clk);
        strobe_i = 0; event_i = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        enable_i = 1; mask_i = 1;
        @(negedge clk);
        check("R10 count", 32'(rec_count_o), 0);
        check("R10 full", 32'(full_o), 0);

        // idx0: solid run of 5 (R1, R2)
        for (int i = 0; i < 5; i++) tick(1);
        strobe(0); exp_mem[0] = 5;
        // idx1: gated by enable and mask (R1)
        enable_i = 0; for (int i = 0; i < 4; i++) tick(1);
        enable_i = 1; for (int i = 0; i < 3; i++) tick(1);
        mask_i = 0;   for (int i = 0; i < 2; i++) tick(1);
        mask_i = 1;
        strobe(0); exp_mem[1] = 3;
        // idx2: alternating pattern (R1)
        for (int i = 0; i < 10; i++) tick(i[0] == 1'b0);
        strobe(0); exp_mem[2] = 5;
        // idx3/idx4: event during strobe (R4)
        for (int i = 0; i < 3; i++) tick(1);
        strobe(1); exp_mem[3] = 3;
        strobe(0); exp_mem[4] = 1;
        // idx5: value mode activity is not counted (R6)
        for (int i = 0; i < 2; i++) tick(1);
        mode_i = 1; for (int i = 0; i < 4; i++) tick(1);
        mode_i = 0;
        strobe(0); exp_mem[5] = 2;
        // idx6: value capture (R6)
        mode_i = 1; value_i = 32'h1234_5678;
        strobe(1); exp_mem[6] = 32'h1234_5678;
        mode_i = 0;
        check("R3 count after 7", 32'(rec_count_o), 7);
        for (int i = 0; i < 7; i++) rd(i, exp_mem[i], "R2 R9 early record");

        // fill the store (R3, R5)
        for (int i = 7; i < DP; i++) begin
            for (int k = 0; k < i % 4; k++) tick(1);
            strobe(0); exp_mem[i] = 32'(i % 4);
        end
        check("R5 full", 32'(full_o), 1);
        check("R5 count at depth", 32'(rec_count_o), DP);
        for (int i = 0; i < 3; i++) tick(1);
        strobe(1);
        strobe(0);
        check("R5 full held", 32'(full_o), 1);
        check("R5 count held", 32'(rec_count_o), DP);
        for (int i = 0; i < DP; i++) rd(i, exp_mem[i], "R3 stored record");

        // start colliding with a strobe (R7)
        start_i = 1; event_i = 1; strobe_i = 1;
        @(negedge clk);
        start_i = 0; strobe_i = 0; event_i = 0;
        check("R7 count cleared", 32'(rec_count_o), 0);
        check("R7 full cleared", 32'(full_o), 0);
        for (int i = 0; i < 2; i++) tick(1);
        strobe(0);
        check("R7 one record", 32'(rec_count_o), 1);
        rd(0, 2, "R7 counter cleared by start");
        rd(1, exp_mem[1], "R7 old record untouched");

        // saturation on narrow instance (R8)
        s_event = 1;
        repeat (300) @(negedge clk);
        s_event = 0; s_strobe = 1;
        @(negedge clk);
        s_strobe = 0;
        s_rd_addr = 0;
        @(negedge clk);
        check("R8 saturated", 32'(s_rd_data), 32'hFF);
        s_strobe = 1;
        repeat (4) @(negedge clk);
        s_strobe = 0;
        check("R5 narrow full", 32'(s_full), 1);
        check("R5 narrow count", 32'(s_count), SDP);
        s_rd_addr = 1;
        @(negedge clk);
        check("R2 cleared after saturation", 32'(s_rd_data), 0);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule